// File: doc/BRIEF.md
# Serial Control Port Slave

This block is the register-access end of a four-wire serial control link. An external master frames each transaction by pulling the select line low, clocks a 16-bit header and then a data word into the block, and releases the select line to end the frame. The header carries a read/write flag and a 10-bit address. The address picks one of two 256-word parameter RAMs, or one of four control registers kept for each of two processors. The block commits writes to the registers it holds. It drives the write and read ports of the two parameter RAMs, which sit outside it, and shifts RAM read data back on a three-state serial output.

All serial pins are synchronised into the system clock `clk`. The block samples them there, so each high phase and each low phase of the serial clock must last at least six `clk` cycles. The parameter RAMs are expected to return read data one clock after their read strobe. The data word length follows the target. RAM words and the level, spreading and dialog registers carry 22 bits in 3 bytes. The control register carries 11 bits in 2 bytes. In both cases the data is right-aligned and sent MSB first. Only the RAM regions can be read back.

Top module: `ctl_spi_slave`

## Requirements
- R1: A frame starts when `sel_n` falls and ends when it rises. While `sel_n` is low, `sdi` is sampled on each rising `sclk` edge. The first 16 bits form the header, MSB first: header bit 15 is the flag (0 = write, 1 = read), bits 14..10 are ignored, and bits 9..0 are the address.
- R2: A write frame to address 0..255 (processor 0) or 512..767 (processor 1) carries 24 data bits after the header. The top 2 data bits are ignored. After `sel_n` rises, the block gives one single-cycle `ram_we` pulse on the bit of that processor only. During that pulse `ram_addr` holds address bits 7..0 and `ram_wdata` holds the low 22 data bits.
- R3: Register writes use these addresses for processor 0, and the same addresses plus 512 for processor 1: 256 is the control register (16 data bits, low 11 kept), 258 is the level register, 259 is the spreading register and 260 is the dialog register. Each of the last three takes 24 data bits and keeps the low 22.
- R4: A write is committed only if the number of rising `sclk` edges in the frame equals exactly 16 plus the data length of the target. A frame with fewer or more edges changes no register and gives no `ram_we`.
- R5: Write frames to 257, 261..511, 769 and 773..1023 change no register and give no `ram_we`.
- R6: A read frame to a RAM address gives one single-cycle `ram_re` pulse on that processor's bit, with `ram_addr` set to address bits 7..0. `sdo` then shifts 24 bits, MSB first: two zeros followed by the 22-bit RAM word. A new bit is driven after each falling `sclk` edge, starting with the first falling edge after the 16th rising edge.
- R7: `sdo` is high-impedance during the header, during any frame that is not a RAM read, and between frames. It returns to high-impedance within three `clk` cycles after the synchronised `sel_n` goes high.
- R8: Read frames, including reads of write-only registers, change no register and give no `ram_we`.
- R9: A synchronous active-low reset `rst_n` clears all registers to zero, clears the RAM strobes and leaves `sdo` high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial bit clock from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Three-state serial read data |
| ctrl_q | output | NPROC*CTRL_W | Control register per processor |
| lvl_q | output | NPROC*WORD_W | Output level register per processor |
| sprd_q | output | NPROC*WORD_W | Stereo spreading register per processor |
| dlg_q | output | NPROC*WORD_W | Dialog enhancement register per processor |
| ram_we | output | NPROC | Parameter RAM write strobe per processor |
| ram_re | output | NPROC | Parameter RAM read strobe per processor |
| ram_addr | output | 8 | Parameter RAM word index |
| ram_wdata | output | WORD_W | Parameter RAM write data |
| ram_rdata | input | NPROC*WORD_W | Parameter RAM read data, valid one clock after `ram_re` |

## Verification
The bench writes every register of both processors with distinct values and compares each output. A mix-up between processors, or an off-by-one in the register offsets, shows up as a value in the wrong register. It writes RAM words at the ends of both regions and reads them back over `sdo`. A slip in the serial bit alignment, or a missing zero pad, would return shifted data. A wrong processor bit would hit the other RAM. Frames one bit short and one bit long, a control-register frame of full 24-bit length, writes to reserved and unmapped addresses, and header pad bits set to ones are all aimed at decode and length logic that accepts too much. The bench also checks that reads of write-only registers leave `sdo` floating and change nothing, which catches an output enable that fires on every read.

// File: rtl/ctl_spi_pkg.sv
package ctl_spi_pkg;

   // width of the word index inside one parameter RAM region
   localparam int RAM_AW = 8;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_RAM,
      TGT_CTRL,
      TGT_LVL,
      TGT_SPRD,
      TGT_DLG
   } tgt_e;

   typedef struct packed {
      tgt_e              tgt;
      logic              proc;
      logic [RAM_AW-1:0] idx;
   } hit_t;

endpackage

// File: rtl/ctl_spi_sync.sv
module ctl_spi_sync #(
   parameter int             STAGES  = 2,
   parameter int             W       = 3,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pipe <= {STAGES{RST_VAL}};
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/ctl_spi_decode.sv
module ctl_spi_decode
   import ctl_spi_pkg::*;
#(
   parameter int ADDR_W = RAM_AW + 2
) (
   input  logic [ADDR_W-1:0] addr,
   output hit_t              hit
);

   localparam int PROC_BIT = ADDR_W - 1;
   localparam int REG_BIT  = ADDR_W - 2;

   always_comb begin
      hit.proc = addr[PROC_BIT];
      hit.idx  = addr[RAM_AW-1:0];
      hit.tgt  = TGT_NONE;
      if (!addr[REG_BIT]) begin
         hit.tgt = TGT_RAM;
      end else begin
         case (addr[RAM_AW-1:0])
            RAM_AW'(0): hit.tgt = TGT_CTRL;
            RAM_AW'(2): hit.tgt = TGT_LVL;
            RAM_AW'(3): hit.tgt = TGT_SPRD;
            RAM_AW'(4): hit.tgt = TGT_DLG;
            default:    hit.tgt = TGT_NONE;
         endcase
      end
   end

endmodule

// File: rtl/ctl_spi_regbank.sv
module ctl_spi_regbank #(
   parameter int NPROC  = 2,
   parameter int WORD_W = 22,
   parameter int CTRL_W = 11
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NPROC-1:0]                  wr_ctrl,
   input  logic [NPROC-1:0]                  wr_lvl,
   input  logic [NPROC-1:0]                  wr_sprd,
   input  logic [NPROC-1:0]                  wr_dlg,
   input  logic [WORD_W-1:0]                 wdata,
   output logic [NPROC-1:0][CTRL_W-1:0]      ctrl_q,
   output logic [NPROC-1:0][WORD_W-1:0]      lvl_q,
   output logic [NPROC-1:0][WORD_W-1:0]      sprd_q,
   output logic [NPROC-1:0][WORD_W-1:0]      dlg_q
);

   for (genvar p = 0; p < NPROC; p++) begin : g_proc
      logic [CTRL_W-1:0] r_ctrl;
      logic [WORD_W-1:0] r_lvl, r_sprd, r_dlg;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r_ctrl <= '0;
            r_lvl  <= '0;
            r_sprd <= '0;
            r_dlg  <= '0;
         end else begin
            if (wr_ctrl[p]) r_ctrl <= wdata[CTRL_W-1:0];
            if (wr_lvl[p])  r_lvl  <= wdata;
            if (wr_sprd[p]) r_sprd <= wdata;
            if (wr_dlg[p])  r_dlg  <= wdata;
         end
      end

      assign ctrl_q[p] = r_ctrl;
      assign lvl_q[p]  = r_lvl;
      assign sprd_q[p] = r_sprd;
      assign dlg_q[p]  = r_dlg;
   end

endmodule

// File: rtl/ctl_spi_slave.sv
module ctl_spi_slave
   import ctl_spi_pkg::*;
#(
   parameter int NPROC       = 2,
   parameter int WORD_W      = 22,
   parameter int CTRL_W      = 11,
   parameter int PAD_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sel_n,
   input  logic                         sclk,
   input  logic                         sdi,
   output logic                         sdo,
   output logic [NPROC-1:0][CTRL_W-1:0] ctrl_q,
   output logic [NPROC-1:0][WORD_W-1:0] lvl_q,
   output logic [NPROC-1:0][WORD_W-1:0] sprd_q,
   output logic [NPROC-1:0][WORD_W-1:0] dlg_q,
   output logic [NPROC-1:0]             ram_we,
   output logic [NPROC-1:0]             ram_re,
   output logic [RAM_AW-1:0]            ram_addr,
   output logic [WORD_W-1:0]            ram_wdata,
   input  logic [NPROC-1:0][WORD_W-1:0] ram_rdata
);

   localparam int ADDR_W     = RAM_AW + 2;
   localparam int HDR_W      = 1 + PAD_W + ADDR_W;
   localparam int LONG_BITS  = ((WORD_W + 7) / 8) * 8;
   localparam int SHORT_BITS = ((CTRL_W + 7) / 8) * 8;
   localparam int CNT_MAX    = HDR_W + LONG_BITS + 1;
   localparam int CNT_W      = $clog2(CNT_MAX + 1);

   // elaboration-time parameter checks
   if (NPROC != 2) begin : g_bad_nproc
      $error("NPROC must be 2: the address carries one processor bit");
   end
   if (CTRL_W > WORD_W) begin : g_bad_ctrl
      $error("CTRL_W must not exceed WORD_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // ---------------- pin synchronisation and edge detection
   logic sel_s, sclk_s, sdi_s, sel_d, sclk_d;

   ctl_spi_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sel_n, sclk, sdi}),
      .q     ({sel_s, sclk_s, sdi_s})
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_d  <= 1'b1;
         sclk_d <= 1'b0;
      end else begin
         sel_d  <= sel_s;
         sclk_d <= sclk_s;
      end
   end

   logic rise, fall, start, stop;
   assign rise  =  sclk_s & ~sclk_d & ~sel_s;
   assign fall  = ~sclk_s &  sclk_d & ~sel_s;
   assign start = ~sel_s &  sel_d;
   assign stop  =  sel_s & ~sel_d;

   // ---------------- input shifter
   logic [HDR_W-1:0]     hdr_q;
   logic [LONG_BITS-1:0] dat_q;
   logic [CNT_W-1:0]     cnt_q;
   logic                 hdr_done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hdr_q      <= '0;
         dat_q      <= '0;
         cnt_q      <= '0;
         hdr_done_q <= 1'b0;
      end else begin
         hdr_done_q <= rise && (cnt_q == CNT_W'(HDR_W - 1));
         if (start) begin
            cnt_q <= '0;
         end else if (rise) begin
            if (cnt_q < CNT_W'(HDR_W))
               hdr_q <= {hdr_q[HDR_W-2:0], sdi_s};
            else if (cnt_q < CNT_W'(HDR_W + LONG_BITS))
               dat_q <= {dat_q[LONG_BITS-2:0], sdi_s};
            if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // ---------------- header decode
   hit_t hit;
   logic is_rd;
   logic [CNT_W-1:0] need_cnt;

   assign is_rd = hdr_q[HDR_W-1];

   ctl_spi_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (hdr_q[ADDR_W-1:0]),
      .hit  (hit)
   );

   assign need_cnt = (hit.tgt == TGT_CTRL) ? CNT_W'(HDR_W + SHORT_BITS)
                                           : CNT_W'(HDR_W + LONG_BITS);

   logic commit;
   assign commit = stop && !is_rd && (hit.tgt != TGT_NONE) && (cnt_q == need_cnt);

   // ---------------- register strobes
   logic [NPROC-1:0] wr_ctrl, wr_lvl, wr_sprd, wr_dlg;

   for (genvar p = 0; p < NPROC; p++) begin : g_strobe
      logic mine;
      assign mine       = commit && (hit.proc == 1'(p));
      assign wr_ctrl[p] = mine && (hit.tgt == TGT_CTRL);
      assign wr_lvl[p]  = mine && (hit.tgt == TGT_LVL);
      assign wr_sprd[p] = mine && (hit.tgt == TGT_SPRD);
      assign wr_dlg[p]  = mine && (hit.tgt == TGT_DLG);
   end

   ctl_spi_regbank #(.NPROC(NPROC), .WORD_W(WORD_W), .CTRL_W(CTRL_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wr_lvl  (wr_lvl),
      .wr_sprd (wr_sprd),
      .wr_dlg  (wr_dlg),
      .wdata   (dat_q[WORD_W-1:0]),
      .ctrl_q  (ctrl_q),
      .lvl_q   (lvl_q),
      .sprd_q  (sprd_q),
      .dlg_q   (dlg_q)
   );

   // ---------------- RAM port and read shifter
   logic                 ld_q, rd_arm_q, oe_q, sdo_q;
   logic [LONG_BITS-1:0] tx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_we    <= '0;
         ram_re    <= '0;
         ram_addr  <= '0;
         ram_wdata <= '0;
         ld_q      <= 1'b0;
         rd_arm_q  <= 1'b0;
         oe_q      <= 1'b0;
         sdo_q     <= 1'b0;
         tx_q      <= '0;
      end else begin
         ram_we <= '0;
         ram_re <= '0;
         ld_q   <= |ram_re;
         if (commit && hit.tgt == TGT_RAM) begin
            ram_we[hit.proc] <= 1'b1;
            ram_addr         <= hit.idx;
            ram_wdata        <= dat_q[WORD_W-1:0];
         end else if (hdr_done_q && is_rd && hit.tgt == TGT_RAM) begin
            ram_re[hit.proc] <= 1'b1;
            ram_addr         <= hit.idx;
         end
         if (start || stop) begin
            rd_arm_q <= 1'b0;
            oe_q     <= 1'b0;
         end else if (ld_q) begin
            tx_q     <= LONG_BITS'(ram_rdata[hit.proc]);
            rd_arm_q <= 1'b1;
         end else if (fall && rd_arm_q) begin
            sdo_q <= tx_q[LONG_BITS-1];
            tx_q  <= {tx_q[LONG_BITS-2:0], 1'b0};
            oe_q  <= 1'b1;
         end
      end
   end

   assign sdo = oe_q ? sdo_q : 1'bz;

endmodule

// File: rtl/ctl_spi_slave_chk.sv
module ctl_spi_slave_chk #(
   parameter int NPROC  = 2,
   parameter int WORD_W = 22,
   parameter int CTRL_W = 11
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         sel_s,
   input logic                         oe_q,
   input logic                         rd_arm_q,
   input logic                         commit,
   input logic [NPROC-1:0]             ram_we,
   input logic [NPROC-1:0]             ram_re,
   input logic [NPROC-1:0][CTRL_W-1:0] ctrl_q,
   input logic [NPROC-1:0][WORD_W-1:0] lvl_q,
   input logic [NPROC-1:0][WORD_W-1:0] sprd_q,
   input logic [NPROC-1:0][WORD_W-1:0] dlg_q
);

   // R2
   we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ram_we));

   // R2
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we != '0) |=> (ram_we == '0));

   // R6
   re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_re != '0) |=> (ram_re == '0) && $onehot0(ram_re));

   // R7
   oe_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> rd_arm_q);

   // R7
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_s |=> !oe_q);

   // R4
   regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(ctrl_q) && $stable(lvl_q) && $stable(sprd_q) && $stable(dlg_q)));

   // R8
   no_write_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_arm_q |-> (ram_we == '0));

endmodule

bind ctl_spi_slave ctl_spi_slave_chk #(
   .NPROC  (NPROC),
   .WORD_W (WORD_W),
   .CTRL_W (CTRL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_s    (sel_s),
   .oe_q     (oe_q),
   .rd_arm_q (rd_arm_q),
   .commit   (commit),
   .ram_we   (ram_we),
   .ram_re   (ram_re),
   .ctrl_q   (ctrl_q),
   .lvl_q    (lvl_q),
   .sprd_q   (sprd_q),
   .dlg_q    (dlg_q)
);

// File: tb/ctl_spi_slave_tb.sv
`timescale 1ns/1ps
module ctl_spi_slave_tb;

   localparam int HALF = 64;  // 8 clk cycles per serial phase

   logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   wire  sdo;
   logic [1:0][10:0] ctrl_q;
   logic [1:0][21:0] lvl_q, sprd_q, dlg_q;
   logic [1:0]       ram_we, ram_re;
   logic [7:0]       ram_addr;
   logic [21:0]      ram_wdata;
   logic [1:0][21:0] ram_rdata;

   always #4 clk = ~clk;  // 125 MHz

   ctl_spi_slave u_dut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
      .ctrl_q(ctrl_q), .lvl_q(lvl_q), .sprd_q(sprd_q), .dlg_q(dlg_q),
      .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   // external parameter RAM model, one-cycle read latency
   logic [21:0] mem [2][256];
   int n_we = 0;
   always @(posedge clk) begin
      for (int p = 0; p < 2; p++) begin
         if (ram_we[p]) mem[p][ram_addr] <= ram_wdata;
         if (ram_re[p]) ram_rdata[p] <= mem[p][ram_addr];
      end
      if (rst_n && ram_we != 2'b00) n_we++;
   end

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] hdr(input bit rd, input logic [9:0] a, input logic [4:0] pad);
      return {rd, pad, a};
   endfunction

   task automatic frame(input logic [47:0] bits, input int n, output logic [47:0] rx);
      rx = '0;
      sel_n = 1'b0;
      #HALF;
      for (int i = 0; i < n; i++) begin
         sdi = bits[n-1-i];
         #HALF;
         rx[n-1-i] = sdo;
         sclk = 1'b1;
         #HALF;
         sclk = 1'b0;
      end
      #HALF;
      sel_n = 1'b1;
      #(HALF*2);
   endtask

   task automatic wr22(input logic [9:0] a, input logic [21:0] d);
      logic [47:0] rx;
      frame({8'h0, hdr(1'b0, a, 5'h0), 2'b00, d}, 40, rx);
   endtask

   task automatic wr11(input logic [9:0] a, input logic [10:0] d);
      logic [47:0] rx;
      frame({16'h0, hdr(1'b0, a, 5'h0), 5'h0, d}, 32, rx);
   endtask

   task automatic rd(input logic [9:0] a, output logic [23:0] data, output logic [15:0] hdr_rx);
      logic [47:0] rx;
      frame({8'h0, hdr(1'b1, a, 5'h0), 24'h0}, 40, rx);
      data   = rx[23:0];
      hdr_rx = rx[39:24];
   endtask

   // expected register state
   logic [1:0][10:0] e_ctrl;
   logic [1:0][21:0] e_lvl, e_sprd, e_dlg;

   task automatic chk_regs(input string req);
      chk({req, " ctrl"}, 64'(ctrl_q), 64'(e_ctrl));
      chk({req, " lvl"},  64'(lvl_q),  64'(e_lvl));
      chk({req, " sprd"}, 64'(sprd_q), 64'(e_sprd));
      chk({req, " dlg"},  64'(dlg_q),  64'(e_dlg));
   endtask

   task automatic t_reset;
      e_ctrl = '0; e_lvl = '0; e_sprd = '0; e_dlg = '0;
      chk_regs("R9 reset");
      chk("R9 sdo z", 64'(sdo), 64'(1'bz));
      chk("R9 ram_we", 64'(ram_we), 64'h0);
      chk("R9 ram_re", 64'(ram_re), 64'h0);
   endtask

   task automatic t_regs;
      wr11(10'd256, 11'h5A3);  e_ctrl[0] = 11'h5A3;
      wr22(10'd258, 22'h12345); e_lvl[0]  = 22'h12345;
      wr22(10'd259, 22'h2ABCDE); e_sprd[0] = 22'h2ABCDE;
      wr22(10'd260, 22'h3FFFFF); e_dlg[0]  = 22'h3FFFFF;
      wr11(10'd768, 11'h07F);  e_ctrl[1] = 11'h07F;
      wr22(10'd770, 22'h0F0F0F); e_lvl[1]  = 22'h0F0F0F;
      wr22(10'd771, 22'h155555); e_sprd[1] = 22'h155555;
      wr22(10'd772, 22'h000001); e_dlg[1]  = 22'h000001;
      chk_regs("R3 register writes");
      chk("R3 no ram write", 64'(n_we), 64'd0);
   endtask

   task automatic t_pad_bits;
      logic [47:0] rx;
      // R1: header bits 14..10 set to ones are ignored
      frame({8'h0, hdr(1'b0, 10'd258, 5'h1F), 2'b11, 22'h0A5A5A}, 40, rx);
      e_lvl[0] = 22'h0A5A5A;
      chk_regs("R1 pad bits ignored");
   endtask

   task automatic t_ram;
      logic [23:0] d;
      logic [15:0] h;
      int base;
      base = n_we;
      wr22(10'd0,   22'h111111);
      wr22(10'd255, 22'h2DEAD5);
      wr22(10'd512, 22'h0BEEF0);
      wr22(10'd767, 22'h3C0FFE);
      chk("R2 ram_we pulses", 64'(n_we - base), 64'd4);
      chk("R2 ram0[0]",   64'(mem[0][0]),   64'h111111);
      chk("R2 ram0[255]", 64'(mem[0][255]), 64'h2DEAD5);
      chk("R2 ram1[0]",   64'(mem[1][0]),   64'h0BEEF0);
      chk("R2 ram1[255]", 64'(mem[1][255]), 64'h3C0FFE);
      rd(10'd255, d, h);
      chk("R6 read ram0[255]", 64'(d), 64'h2DEAD5);
      chk("R7 sdo z in header", 64'(h), 64'({16{1'bz}}));
      chk("R7 sdo z after read", 64'(sdo), 64'(1'bz));
      rd(10'd512, d, h);
      chk("R6 read ram1[0]", 64'(d), 64'h0BEEF0);
      rd(10'd767, d, h);
      chk("R6 read ram1[255]", 64'(d), 64'h3C0FFE);
      chk("R8 no ram write on read", 64'(n_we - base), 64'd4);
      chk_regs("R8 regs after ram reads");
   endtask

   task automatic t_length;
      logic [47:0] rx;
      int base;
      base = n_we;
      frame({9'h0, hdr(1'b0, 10'd770, 5'h0), 2'b00, 22'h3AAAAA, 1'b1} >> 2, 39, rx);
      frame({7'h0, hdr(1'b0, 10'd770, 5'h0), 2'b00, 22'h3AAAAA, 1'b1}, 41, rx);
      frame({8'h0, hdr(1'b0, 10'd768, 5'h0), 24'h000123}, 40, rx);
      frame({8'h0, hdr(1'b0, 10'd10,  5'h0), 2'b00, 21'h0, 1'b1}, 39, rx);
      chk_regs("R4 wrong-length frames");
      chk("R4 no ram write", 64'(n_we - base), 64'd0);
      chk("R4 ram0[10] untouched", 64'(mem[0][10]), 64'h0);
   endtask

   task automatic t_reserved;
      int base;
      base = n_we;
      wr22(10'd257, 22'h3FFFFF);
      wr22(10'd769, 22'h3FFFFF);
      wr22(10'd261, 22'h3FFFFF);
      wr22(10'd1023, 22'h3FFFFF);
      wr11(10'd300, 11'h7FF);
      chk_regs("R5 reserved writes");
      chk("R5 no ram write", 64'(n_we - base), 64'd0);
   endtask

   task automatic t_read_reg;
      logic [23:0] d;
      logic [15:0] h;
      int base;
      base = n_we;
      rd(10'd258, d, h);
      chk("R7 read of write-only reg keeps sdo z", 64'(d), 64'({24{1'bz}}));
      rd(10'd768, d, h);
      chk("R7 read of ctrl reg keeps sdo z", 64'(d), 64'({24{1'bz}}));
      chk_regs("R8 regs after register reads");
      chk("R8 no ram write", 64'(n_we - base), 64'd0);
   endtask

   task automatic t_reset_again;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
   endtask

   initial begin
      for (int p = 0; p < 2; p++)
         for (int i = 0; i < 256; i++) mem[p][i] = '0;
      ram_rdata = '0;
      #80 rst_n = 1'b1;
      #80;
      t_reset();
      t_regs();
      t_pad_bits();
      t_ram();
      t_length();
      t_reserved();
      t_read_reg();
      t_reset_again();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule